// File: doc/BRIEF.md
# PCI Error Signaling Controller

This block is the error-reporting front of a PCI bus agent. It takes one-cycle strobes for the errors that the agent's other logic detects. These are single-bit and multi-bit ECC errors, DRAM parity errors, a target abort on a cycle the agent started, an address-phase parity error, a data-phase parity error, and the bus PERR# line seen asserted by another agent. The block decides which of these are reported and drives the active-low SERR# and PERR# pins to match.

SERR# collects every non-data error source under two levels of enable. A master SERR# enable in the command register gates all of them. Each memory-error source and the sampled-PERR# source also has its own enable in a separate error-command register. The target abort needs only the master enable. Address parity goes to SERR# and never to PERR#, and it needs the parity enable as well. Data-phase parity is checked only when this agent is receiving the data, and it is reported on PERR#. Each reported error sets a sticky status bit that software clears by writing a one to it. Software reaches all registers through a simple word-wide write port and a combinational read port.

Top module: `pci_err_signal`

## Requirements
- R1: After reset the command register (address 04h) reads 0006h. The error-command register (address 50h) and the status register (address 52h) read 0000h. SERR# is not driven (serrOe=0, serrN=1) and perrN=1.
- R2: In the command register only bit 8 (SERR# enable) and bit 6 (parity enable) are writable. Bits 2:1 always read 1 and every other bit always reads 0, so a write of FFFFh reads back 0146h.
- R3: The error-command register has four writable bits: bit 0 single-bit ECC, bit 1 multi-bit ECC, bit 2 DRAM parity, bit 3 sampled PERR#. Bits 15:4 read 0.
- R4: When command bit 8 is 0, SERR# is never driven and no SERR# source sets a status bit, whatever the events and the other enables.
- R5: A target-abort strobe drives SERR# (serrOe=1, serrN=0) for exactly the one clock after the strobe edge, provided only that command bit 8 is set.
- R6: An address-parity strobe drives SERR# only when command bits 8 and 6 are both set. It never asserts PERR#.
- R7: Single-bit ECC, multi-bit ECC and DRAM parity strobes each drive SERR# only when their own error-command bit and command bit 8 are set.
- R8: A sampled-PERR# strobe drives SERR# only when error-command bit 3 and command bit 8 are set.
- R9: A data-parity strobe is checked only when the agent receives the data, that is a read while it is the initiator (isRead=1, selfInit=1) or a write while it is the target (isRead=0, selfInit=0). When command bit 6 is set, perrN is low for exactly one clock, the second clock after the strobe edge. A data-parity strobe never drives SERR#.
- R10: Status bits are sticky. A reported error sets its bit: bit 0 single-bit ECC, bit 1 multi-bit ECC, bit 2 DRAM parity, bit 3 target abort, bit 4 address parity, bit 5 data parity, bit 6 sampled PERR#. An error that is not reported sets no bit.
- R11: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R12: serrN is low exactly when serrOe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 8 | Register byte address for read and write |
| cfgWData | input | 16 | Register write data |
| cfgRData | output | 16 | Register read data, combinational from cfgAddr |
| evSbe | input | 1 | Single-bit ECC error strobe |
| evMbe | input | 1 | Multi-bit ECC error strobe |
| evDramPar | input | 1 | DRAM parity error strobe |
| evTgtAbort | input | 1 | Target abort on a self-initiated cycle |
| evAddrPar | input | 1 | Address-phase parity error strobe |
| evDataPar | input | 1 | Data-phase parity error strobe |
| evPerrSeen | input | 1 | PERR# sampled asserted on the bus |
| isRead | input | 1 | The current data phase is a read |
| selfInit | input | 1 | This agent is the initiator of the current cycle |
| serrOe | output | 1 | SERR# driver enable |
| serrN | output | 1 | SERR# level, low while driven |
| perrN | output | 1 | PERR#, active low |

## Verification
A wrong enable bit in the control path shows up one clock after a strobe. SERR# either pulses when it should stay released or stays released when it should pulse. The matching status bit is set or left clear in the same cycle and can be read back at once. A wrong receiver decision or a broken parity pipeline shows up on PERR# two clocks after the strobe. It appears as a missing pulse, a pulse in the wrong cycle, or a pulse that lasts more than one clock. A fault in the fixed command bits or in the write-one-to-clear masking is visible on the read port in the cycle right after the write.

// File: rtl/errsig_pkg.sv
`timescale 1ns/1ps
package errsig_pkg;
  localparam int STS_W = 7;
  localparam int STS_SBE = 0;
  localparam int STS_MBE = 1;
  localparam int STS_DRAM = 2;
  localparam int STS_TABORT = 3;
  localparam int STS_APAR = 4;
  localparam int STS_DPAR = 5;
  localparam int STS_PSEEN = 6;

  localparam int ECMD_W = 4;
  localparam int CMD_SERR_BIT = 8;
  localparam int CMD_PERR_BIT = 6;
  localparam logic [15:0] CMD_WMASK = 16'h0140;
  localparam logic [15:0] CMD_FIXED = 16'h0006;

  typedef struct packed {
    logic [STS_W-1:0] stsSet;
  } ctlStrobes_t;
endpackage

// File: rtl/errsig_regs.sv
`timescale 1ns/1ps
module errsig_regs
  import errsig_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] ECMD_ADDR = 8'h50,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h52
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWData,
  output logic [DATA_W-1:0] cfgRData,
  input  ctlStrobes_t       strobes,
  output logic              serrEn,
  output logic              perrEn,
  output logic [ECMD_W-1:0] ecmdEn
);
  localparam logic [DATA_W-1:0] ECMD_WMASK = DATA_W'((1 << ECMD_W) - 1);

  logic [DATA_W-1:0] cmdQ;
  logic [DATA_W-1:0] ecmdQ;
  logic [STS_W-1:0]  stsQ;
  logic wrCmd, wrEcmd, wrSts;

  assign wrCmd  = cfgWe && (cfgAddr == CMD_ADDR);
  assign wrEcmd = cfgWe && (cfgAddr == ECMD_ADDR);
  assign wrSts  = cfgWe && (cfgAddr == STS_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      ecmdQ <= '0;
    end else begin
      if (wrCmd)  cmdQ  <= cfgWData & DATA_W'(CMD_WMASK);
      if (wrEcmd) ecmdQ <= cfgWData & ECMD_WMASK;
    end
  end

  // one sticky bit per source; a set in the same cycle beats a clear
  for (genvar b = 0; b < STS_W; b++) begin : gSts
    always_ff @(posedge clk) begin
      if (!rstN)                      stsQ[b] <= 1'b0;
      else if (strobes.stsSet[b])     stsQ[b] <= 1'b1;
      else if (wrSts && cfgWData[b])  stsQ[b] <= 1'b0;
    end
  end

  assign serrEn = cmdQ[CMD_SERR_BIT];
  assign perrEn = cmdQ[CMD_PERR_BIT];
  assign ecmdEn = ecmdQ[ECMD_W-1:0];

  always_comb begin
    cfgRData = '0;
    if (cfgAddr == CMD_ADDR)       cfgRData = cmdQ | DATA_W'(CMD_FIXED);
    else if (cfgAddr == ECMD_ADDR) cfgRData = ecmdQ;
    else if (cfgAddr == STS_ADDR)  cfgRData = DATA_W'(stsQ);
  end

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !($past(wrSts) && $past(rstN)) |-> ((stsQ & $past(stsQ)) == $past(stsQ))) // R11
    else $error("sticky status bit dropped without a clear");

  AST_CMD_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == CMD_ADDR) |-> ((cfgRData & ~DATA_W'(CMD_WMASK)) == DATA_W'(CMD_FIXED))) // R2
    else $error("command register fixed bits corrupted");

  AST_STS_FROM_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsQ[STS_TABORT]) |-> $past(strobes.stsSet[STS_TABORT])) // R10
    else $error("status set with no reported event");
endmodule

// File: rtl/errsig_ctrl.sv
`timescale 1ns/1ps
module errsig_ctrl
  import errsig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evSbe,
  input  logic              evMbe,
  input  logic              evDramPar,
  input  logic              evTgtAbort,
  input  logic              evAddrPar,
  input  logic              evDataPar,
  input  logic              evPerrSeen,
  input  logic              isRead,
  input  logic              selfInit,
  input  logic              serrEn,
  input  logic              perrEn,
  input  logic [ECMD_W-1:0] ecmdEn,
  output ctlStrobes_t       strobes,
  output logic              serrOe,
  output logic              perrOut
);
  logic qSbe, qMbe, qDram, qTab, qApar, qDpar, qPseen;
  logic isReceiver, serrReq, perrStage;

  // agent takes the data: read as initiator, or write as target
  assign isReceiver = (isRead == selfInit);

  assign qSbe   = evSbe      && ecmdEn[0] && serrEn;
  assign qMbe   = evMbe      && ecmdEn[1] && serrEn;
  assign qDram  = evDramPar  && ecmdEn[2] && serrEn;
  assign qPseen = evPerrSeen && ecmdEn[3] && serrEn;
  assign qTab   = evTgtAbort && serrEn;
  assign qApar  = evAddrPar  && serrEn && perrEn;
  assign qDpar  = evDataPar  && isReceiver && perrEn;

  assign serrReq = qSbe | qMbe | qDram | qPseen | qTab | qApar;

  always_comb begin
    strobes = '0;
    strobes.stsSet[STS_SBE]    = qSbe;
    strobes.stsSet[STS_MBE]    = qMbe;
    strobes.stsSet[STS_DRAM]   = qDram;
    strobes.stsSet[STS_TABORT] = qTab;
    strobes.stsSet[STS_APAR]   = qApar;
    strobes.stsSet[STS_DPAR]   = qDpar;
    strobes.stsSet[STS_PSEEN]  = qPseen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      serrOe    <= 1'b0;
      perrStage <= 1'b0;
      perrOut   <= 1'b0;
    end else begin
      serrOe    <= serrReq;
      perrStage <= qDpar;
      perrOut   <= perrStage;
    end
  end

  AST_SERR_MASTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !serrEn |=> !serrOe) // R4
    else $error("SERR# driven while disabled");

  AST_SERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    serrOe |-> $past(evSbe | evMbe | evDramPar | evTgtAbort | evAddrPar | evPerrSeen)) // R5
    else $error("SERR# driven with no source event");

  AST_PERR_TWO_LATE: assert property (@(posedge clk) disable iff (!rstN)
    perrOut |-> ($past(evDataPar, 2) && $past(perrEn, 2))) // R9
    else $error("PERR# without an enabled data-parity event");

  AST_APAR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (evAddrPar && !perrEn && !evSbe && !evMbe && !evDramPar && !evTgtAbort && !evPerrSeen) |=> !serrOe) // R6
    else $error("address parity reported with parity disabled");
endmodule

// File: rtl/pci_err_signal.sv
`timescale 1ns/1ps
module pci_err_signal
  import errsig_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWData,
  output logic [DATA_W-1:0] cfgRData,
  input  logic              evSbe,
  input  logic              evMbe,
  input  logic              evDramPar,
  input  logic              evTgtAbort,
  input  logic              evAddrPar,
  input  logic              evDataPar,
  input  logic              evPerrSeen,
  input  logic              isRead,
  input  logic              selfInit,
  output logic              serrOe,
  output logic              serrN,
  output logic              perrN
);
  ctlStrobes_t       strobes;
  logic              serrEn, perrEn, perrOut;
  logic [ECMD_W-1:0] ecmdEn;

  errsig_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uRegs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWData(cfgWData), .cfgRData(cfgRData), .strobes(strobes),
    .serrEn(serrEn), .perrEn(perrEn), .ecmdEn(ecmdEn)
  );

  errsig_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .evSbe(evSbe), .evMbe(evMbe),
    .evDramPar(evDramPar), .evTgtAbort(evTgtAbort), .evAddrPar(evAddrPar),
    .evDataPar(evDataPar), .evPerrSeen(evPerrSeen), .isRead(isRead),
    .selfInit(selfInit), .serrEn(serrEn), .perrEn(perrEn), .ecmdEn(ecmdEn),
    .strobes(strobes), .serrOe(serrOe), .perrOut(perrOut)
  );

  assign serrN = ~serrOe;
  assign perrN = ~perrOut;

  AST_SERR_PIN_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    serrOe == !serrN) // R12
    else $error("SERR# level disagrees with its enable");

  AST_PERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (!perrN && !$past(evDataPar)) |=> perrN) // R9
    else $error("PERR# held too long");
endmodule

// File: tb/pci_err_signal_test.sv
`timescale 1ns/1ps
module pci_err_signal_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [7:0] cfgAddr = 8'h00;
  logic [15:0] cfgWData = 16'h0;
  logic [15:0] cfgRData;
  logic evSbe = 0, evMbe = 0, evDramPar = 0, evTgtAbort = 0;
  logic evAddrPar = 0, evDataPar = 0, evPerrSeen = 0;
  logic isRead = 0, selfInit = 0;
  logic serrOe, serrN, perrN;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  localparam logic [7:0] A_CMD = 8'h04, A_ECMD = 8'h50, A_STS = 8'h52;
  // event vector bits: 0 sbe,1 mbe,2 dram,3 tabort,4 apar,5 dpar,6 perr seen

  pci_err_signal uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWData(cfgWData), .cfgRData(cfgRData), .evSbe(evSbe), .evMbe(evMbe),
    .evDramPar(evDramPar), .evTgtAbort(evTgtAbort), .evAddrPar(evAddrPar),
    .evDataPar(evDataPar), .evPerrSeen(evPerrSeen), .isRead(isRead),
    .selfInit(selfInit), .serrOe(serrOe), .serrN(serrN), .perrN(perrN)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRData;
  endtask

  // s1/s2: serrOe one and two clocks after the strobe edge; p1/p2/p3: perrN
  task automatic fire(input logic [6:0] ev, input logic rd, input logic init,
                      output logic s1, output logic s2,
                      output logic p1, output logic p2, output logic p3);
    @(negedge clk);
    {evPerrSeen, evDataPar, evAddrPar, evTgtAbort, evDramPar, evMbe, evSbe} = ev;
    isRead = rd; selfInit = init;
    @(posedge clk); #1 s1 = serrOe; p1 = perrN;
    @(negedge clk);
    {evPerrSeen, evDataPar, evAddrPar, evTgtAbort, evDramPar, evMbe, evSbe} = '0;
    @(posedge clk); #1 s2 = serrOe; p2 = perrN;
    @(posedge clk); #1 p3 = perrN;
  endtask

  task automatic clearSts();
    regWrite(A_STS, 16'hFFFF);
  endtask

  task automatic testReset();
    logic [15:0] d;
    check("R1 serrOe", 16'(serrOe), 16'h0);
    check("R1 serrN", 16'(serrN), 16'h1);
    check("R1 perrN", 16'(perrN), 16'h1);
    regRead(A_CMD, d);  check("R1 cmd", d, 16'h0006);
    regRead(A_ECMD, d); check("R1 ecmd", d, 16'h0000);
    regRead(A_STS, d);  check("R1 sts", d, 16'h0000);
  endtask

  task automatic testRegMasks();
    logic [15:0] d;
    regWrite(A_CMD, 16'hFFFF); regRead(A_CMD, d); check("R2 cmd ones", d, 16'h0146);
    regWrite(A_CMD, 16'h0000); regRead(A_CMD, d); check("R2 cmd zeros", d, 16'h0006);
    regWrite(A_ECMD, 16'hFFFF); regRead(A_ECMD, d); check("R3 ecmd ones", d, 16'h000F);
    regWrite(A_ECMD, 16'h0005); regRead(A_ECMD, d); check("R3 ecmd pattern", d, 16'h0005);
  endtask

  task automatic testMasterGate();
    logic s1, s2, p1, p2, p3; logic [15:0] d;
    regWrite(A_CMD, 16'h0040); regWrite(A_ECMD, 16'h000F); clearSts();
    fire(7'b1011111, 1'b0, 1'b0, s1, s2, p1, p2, p3);
    check("R4 no serr", 16'(s1), 16'h0);
    check("R12 serrN released", 16'(serrN), 16'h1);
    regRead(A_STS, d); check("R4 no serr status", d, 16'h0000);
  endtask

  task automatic testTargetAbort();
    logic s1, s2, p1, p2, p3; logic [15:0] d;
    regWrite(A_CMD, 16'h0100); regWrite(A_ECMD, 16'h0000); clearSts();
    @(negedge clk); evTgtAbort = 1'b1;
    @(posedge clk); #1 check("R5 serr pulse", 16'(serrOe), 16'h1);
    check("R12 serrN low", 16'(serrN), 16'h0);
    @(negedge clk); evTgtAbort = 1'b0;
    @(posedge clk); #1 check("R5 serr one clock", 16'(serrOe), 16'h0);
    regRead(A_STS, d); check("R10 tabort status bit3", d, 16'h0008);
    s1 = 0; s2 = 0; p1 = 0; p2 = 0; p3 = 0;
  endtask

  task automatic testAddrParity();
    logic s1, s2, p1, p2, p3; logic [15:0] d;
    clearSts();
    regWrite(A_CMD, 16'h0100);
    fire(7'b0010000, 1'b0, 1'b0, s1, s2, p1, p2, p3);
    check("R6 apar needs perrEn", 16'(s1), 16'h0);
    regWrite(A_CMD, 16'h0140);
    fire(7'b0010000, 1'b1, 1'b1, s1, s2, p1, p2, p3);
    check("R6 apar serr", 16'(s1), 16'h1);
    check("R6 apar no perr", 16'({p1, p2, p3}), 16'h7);
    regRead(A_STS, d); check("R10 apar status bit4", d, 16'h0010);
  endtask

  task automatic testEcc();
    logic s1, s2, p1, p2, p3; logic [15:0] d;
    regWrite(A_CMD, 16'h0100); regWrite(A_ECMD, 16'h0001); clearSts();
    fire(7'b0000001, 1'b0, 1'b0, s1, s2, p1, p2, p3); check("R7 sbe enabled", 16'(s1), 16'h1);
    fire(7'b0000010, 1'b0, 1'b0, s1, s2, p1, p2, p3); check("R7 mbe masked", 16'(s1), 16'h0);
    fire(7'b0000100, 1'b0, 1'b0, s1, s2, p1, p2, p3); check("R7 dram masked", 16'(s1), 16'h0);
    regRead(A_STS, d); check("R10 only sbe bit0", d, 16'h0001);
    regWrite(A_ECMD, 16'h0006);
    fire(7'b0000010, 1'b0, 1'b0, s1, s2, p1, p2, p3); check("R7 mbe enabled", 16'(s1), 16'h1);
    fire(7'b0000100, 1'b0, 1'b0, s1, s2, p1, p2, p3); check("R7 dram enabled", 16'(s1), 16'h1);
    regRead(A_STS, d); check("R10 mbe dram bits", d, 16'h0007);
  endtask

  task automatic testPerrSeen();
    logic s1, s2, p1, p2, p3; logic [15:0] d;
    regWrite(A_CMD, 16'h0100); regWrite(A_ECMD, 16'h0007); clearSts();
    fire(7'b1000000, 1'b0, 1'b0, s1, s2, p1, p2, p3); check("R8 seen masked", 16'(s1), 16'h0);
    regWrite(A_ECMD, 16'h0008);
    fire(7'b1000000, 1'b0, 1'b0, s1, s2, p1, p2, p3); check("R8 seen enabled", 16'(s1), 16'h1);
    regRead(A_STS, d); check("R10 seen bit6", d, 16'h0040);
  endtask

  task automatic testDataParity();
    logic s1, s2, p1, p2, p3; logic [15:0] d;
    regWrite(A_CMD, 16'h0140); regWrite(A_ECMD, 16'h000F); clearSts();
    fire(7'b0100000, 1'b1, 1'b1, s1, s2, p1, p2, p3);
    check("R9 read initiator timing", 16'({p1, p2, p3}), 16'b101);
    check("R9 no serr", 16'({s1, s2}), 16'h0);
    fire(7'b0100000, 1'b0, 1'b0, s1, s2, p1, p2, p3);
    check("R9 write target", 16'({p1, p2, p3}), 16'b101);
    regRead(A_STS, d); check("R10 dpar bit5", d, 16'h0020);
    clearSts();
    fire(7'b0100000, 1'b1, 1'b0, s1, s2, p1, p2, p3);
    check("R9 read target ignored", 16'({p1, p2, p3}), 16'b111);
    fire(7'b0100000, 1'b0, 1'b1, s1, s2, p1, p2, p3);
    check("R9 write initiator ignored", 16'({p1, p2, p3}), 16'b111);
    regWrite(A_CMD, 16'h0100);
    fire(7'b0100000, 1'b1, 1'b1, s1, s2, p1, p2, p3);
    check("R9 perrEn off", 16'({p1, p2, p3}), 16'b111);
    regRead(A_STS, d); check("R10 ignored dpar no bit", d, 16'h0000);
  endtask

  task automatic testW1c();
    logic [15:0] d;
    regWrite(A_CMD, 16'h0140); regWrite(A_ECMD, 16'h000F); clearSts();
    @(negedge clk); evSbe = 1; evTgtAbort = 1; evPerrSeen = 1;
    @(negedge clk); evSbe = 0; evTgtAbort = 0; evPerrSeen = 0;
    regRead(A_STS, d); check("R10 three bits", d, 16'h0049);
    regWrite(A_STS, 16'h0008); regRead(A_STS, d); check("R11 clear one", d, 16'h0041);
    regWrite(A_STS, 16'h0000); regRead(A_STS, d); check("R11 write zero keeps", d, 16'h0041);
    @(negedge clk); cfgWe = 1; cfgAddr = A_STS; cfgWData = 16'h0041; evSbe = 1;
    @(negedge clk); cfgWe = 0; evSbe = 0;
    regRead(A_STS, d); check("R11 set beats clear", d, 16'h0001);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegMasks();
    testMasterGate();
    testTargetAbort();
    testAddrParity();
    testEcc();
    testPerrSeen();
    testDataParity();
    testW1c();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule